// File: doc/BRIEF.md
# Doorbell and Message Interrupt Unit

This block keeps a 32-bit doorbell cause register and a 32-bit enable register for each processor in a small cluster. A software-trigger word is written to one global register. Its low bits name a doorbell and a bitmap starting at bit 8 names the target processors. The write latches that doorbell in the cause register of every processor named in the bitmap. Inbound message-signalled interrupts arrive on a separate message port as a target processor and a vector. They land on doorbells 16 to 31 of that processor. The port carries the same information that the message data word (1 << (8 + cpu)) | (16 + vector) would encode.

Each processor reads its own cause and enable registers through the register bus, which carries the processor number as sideband. It acknowledges doorbells by writing zeros to the cause register. Enabled doorbells fold into two interrupt lines per processor. One line covers the inter-processor doorbells 0 to 7 and the other covers the message doorbells 16 to 31. Doorbells 8 to 15 drive neither line. An option places a register on the interrupt lines.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every cause bit and every enable bit of every processor reads 0, and every interrupt line is low.
- R2: A bus write (bus_global=1, bus_wr=1) to address 0x004 sets cause bit bus_wdata[4:0] in every processor c with bus_wdata[8+c]=1. It changes no other cause bit.
- R3: Bitmap bits for processors numbered NCPU or above are ignored. A per-processor access with bus_cpu at or above NCPU changes nothing and reads 0.
- R4: A write (bus_global=0) to per-processor address 0x008 clears the cause bits of processor bus_cpu where bus_wdata holds 0, and leaves the bits where it holds 1.
- R5: When a trigger and a clearing write reach the same cause bit in the same cycle, the bit ends up set.
- R6: The enable register at per-processor address 0x00C takes the written word as-is. Reads at 0x008 and 0x00C return the cause and enable registers of bus_cpu. Any other address reads 0.
- R7: A cause bit is set by a trigger whatever the value of its enable bit.
- R8: ipi_irq[c] is high exactly when some doorbell 0..7 of processor c is both pending and enabled. msi_irq[c] is high exactly when some doorbell 16..31 is. Doorbells 8..15 affect neither line.
- R9: A message with msg_valid=1, msg_cpu=c and msg_vec=v sets doorbell 16+v of processor c. It takes effect together with a bus trigger in the same cycle. A message to a processor at or above NCPU is ignored.
- R10: With OUT_REG=1 the interrupt lines follow the register state one clock later: after the edge that changes the cause register the line is unchanged, and it changes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_global | input | 1 | 1 selects the global register space, 0 the per-processor space |
| bus_addr | input | ADDR_W | Byte address within the selected space |
| bus_cpu | input | CPU_ID_W | Number of the processor making the access |
| bus_wdata | input | NUM_DB | Write data |
| bus_rdata | output | NUM_DB | Read data (combinational while bus_rd is high) |
| msg_valid | input | 1 | Inbound message strobe |
| msg_cpu | input | CPU_ID_W | Target processor of the message |
| msg_vec | input | VEC_W | Message vector, mapped to doorbell MSI_LO+vec |
| ipi_irq | output | NCPU | Per-processor inter-processor summary interrupt |
| msi_irq | output | NCPU | Per-processor message summary interrupt |

## Verification
The bench builds the unit with NCPU=3 and OUT_REG=1. With three processors, the fourth bitmap bit and processor number 3 become legal encodings that the design must ignore. The registered summary option makes the one-cycle lag of the interrupt lines visible at the ports. Random triggers, clears, enable writes and messages are mixed with same-cycle collisions, and the results are compared against a bench model of all four register pairs.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
   localparam int ADDR_BITS = 12;
   localparam logic [ADDR_BITS-1:0] OFFS_TRIGGER = 12'h004;
   localparam logic [ADDR_BITS-1:0] OFFS_CAUSE   = 12'h008;
   localparam logic [ADDR_BITS-1:0] OFFS_ENABLE  = 12'h00C;
   localparam int MAX_CPUS = 4;
endpackage

// File: rtl/db_trig_dec.sv
module db_trig_dec #(
   parameter int NUM_DB = 32,
   parameter int NCPU   = 4,
   localparam int IDX_W = $clog2(NUM_DB)
) (
   input  logic                         en,
   input  logic [IDX_W-1:0]             idx,
   input  logic [NCPU-1:0]              map,
   output logic [NCPU-1:0][NUM_DB-1:0]  set_mat
);
   logic [NUM_DB-1:0] onehot;
   assign onehot = NUM_DB'(1) << idx;

   for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign set_mat[c] = (en && map[c]) ? onehot : '0;
   end
endmodule

// File: rtl/db_group_or.sv
module db_group_or #(
   parameter int NUM_DB  = 32,
   parameter int LO      = 0,
   parameter int HI      = 7,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_DB-1:0] cause,
   input  logic [NUM_DB-1:0] enable,
   output logic              irq
);
   logic [HI-LO:0] hit;
   logic           any_hit;

   assign hit     = cause[HI:LO] & enable[HI:LO];
   assign any_hit = |hit;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_hit;
      end
      AST_IRQ_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(any_hit)));                          // R10
   end else begin : g_comb
      assign irq = any_hit;
   end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank #(
   parameter int NUM_DB    = 32,
   parameter int IPI_LO    = 0,
   parameter int IPI_HI    = 7,
   parameter int MSI_LO    = 16,
   parameter int MSI_HI    = 31,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_DB-1:0] set_vec,
   input  logic              clr_we,
   input  logic [NUM_DB-1:0] clr_data,
   input  logic              en_we,
   input  logic [NUM_DB-1:0] en_data,
   output logic [NUM_DB-1:0] cause,
   output logic [NUM_DB-1:0] enable,
   output logic              ipi_irq,
   output logic              msi_irq
);
   logic [NUM_DB-1:0] keep;

   assign keep = clr_we ? clr_data : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause  <= '0;
         enable <= '0;
      end else begin
         cause <= (cause & keep) | set_vec;
         if (en_we) enable <= en_data;
      end
   end

   db_group_or #(.NUM_DB(NUM_DB), .LO(IPI_LO), .HI(IPI_HI), .OUT_REG(OUT_REG)) u_ipi (
      .clk(clk), .rst_n(rst_n), .cause(cause), .enable(enable), .irq(ipi_irq));

   db_group_or #(.NUM_DB(NUM_DB), .LO(MSI_LO), .HI(MSI_HI), .OUT_REG(OUT_REG)) u_msi (
      .clk(clk), .rst_n(rst_n), .cause(cause), .enable(enable), .irq(msi_irq));

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((cause & $past(set_vec)) == $past(set_vec)));   // R5
   AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((cause & ~$past(cause) & ~$past(set_vec)) == '0));    // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && set_vec == '0) |=> $stable(cause));                 // R4
   AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we |=> $stable(enable));                                    // R6
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
   import doorbell_pkg::*;
#(
   parameter int NCPU     = 4,
   parameter int NUM_DB   = 32,
   parameter int IPI_LO   = 0,
   parameter int IPI_HI   = 7,
   parameter int MSI_LO   = 16,
   parameter int MSI_HI   = 31,
   parameter int CPU_LSB  = 8,
   parameter int CPU_ID_W = 2,
   parameter int VEC_W    = 4,
   parameter int ADDR_W   = ADDR_BITS,
   parameter bit OUT_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic                bus_global,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [CPU_ID_W-1:0] bus_cpu,
   input  logic [NUM_DB-1:0]   bus_wdata,
   output logic [NUM_DB-1:0]   bus_rdata,
   input  logic                msg_valid,
   input  logic [CPU_ID_W-1:0] msg_cpu,
   input  logic [VEC_W-1:0]    msg_vec,
   output logic [NCPU-1:0]     ipi_irq,
   output logic [NCPU-1:0]     msi_irq
);
   localparam int IDX_W = $clog2(NUM_DB);

   if (NCPU < 1 || NCPU > MAX_CPUS)           begin : g_bad_ncpu  $error("NCPU out of range"); end
   if (NCPU > (1 << CPU_ID_W))                begin : g_bad_idw   $error("CPU_ID_W too narrow"); end
   if (IDX_W > CPU_LSB)                       begin : g_bad_lsb   $error("index overlaps bitmap"); end
   if (CPU_LSB + NCPU > NUM_DB)               begin : g_bad_word  $error("bitmap outside word"); end
   if (IPI_HI >= NUM_DB || IPI_LO > IPI_HI)   begin : g_bad_ipi   $error("bad IPI group"); end
   if (MSI_HI >= NUM_DB || MSI_LO > MSI_HI)   begin : g_bad_msi   $error("bad MSI group"); end
   if ((1 << VEC_W) != MSI_HI - MSI_LO + 1)   begin : g_bad_vec   $error("VEC_W mismatch"); end
   if (ADDR_W != ADDR_BITS)                   begin : g_bad_addr  $error("ADDR_W mismatch"); end

   logic                        trig_we;
   logic [NCPU-1:0]             msg_map;
   logic [IDX_W-1:0]            msg_idx;
   logic [NCPU-1:0][NUM_DB-1:0] bus_set;
   logic [NCPU-1:0][NUM_DB-1:0] msg_set;
   logic [NCPU-1:0][NUM_DB-1:0] cause_all;
   logic [NCPU-1:0][NUM_DB-1:0] enable_all;

   assign trig_we = bus_wr && bus_global && (bus_addr == OFFS_TRIGGER);
   assign msg_idx = IDX_W'(MSI_LO) + IDX_W'(msg_vec);

   for (genvar c = 0; c < NCPU; c++) begin : g_map
      assign msg_map[c] = (msg_cpu == CPU_ID_W'(c));
   end

   db_trig_dec #(.NUM_DB(NUM_DB), .NCPU(NCPU)) u_bus_dec (
      .en(trig_we), .idx(bus_wdata[IDX_W-1:0]), .map(bus_wdata[CPU_LSB +: NCPU]),
      .set_mat(bus_set));

   db_trig_dec #(.NUM_DB(NUM_DB), .NCPU(NCPU)) u_msg_dec (
      .en(msg_valid), .idx(msg_idx), .map(msg_map), .set_mat(msg_set));

   for (genvar c = 0; c < NCPU; c++) begin : g_bank
      logic sel;
      assign sel = bus_wr && !bus_global && (bus_cpu == CPU_ID_W'(c));

      db_cpu_bank #(
         .NUM_DB(NUM_DB), .IPI_LO(IPI_LO), .IPI_HI(IPI_HI),
         .MSI_LO(MSI_LO), .MSI_HI(MSI_HI), .OUT_REG(OUT_REG)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_vec  (bus_set[c] | msg_set[c]),
         .clr_we   (sel && (bus_addr == OFFS_CAUSE)),
         .clr_data (bus_wdata),
         .en_we    (sel && (bus_addr == OFFS_ENABLE)),
         .en_data  (bus_wdata),
         .cause    (cause_all[c]),
         .enable   (enable_all[c]),
         .ipi_irq  (ipi_irq[c]),
         .msi_irq  (msi_irq[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NCPU; c++) begin
         if (bus_rd && !bus_global && bus_cpu == CPU_ID_W'(c)) begin
            if (bus_addr == OFFS_CAUSE)       bus_rdata = cause_all[c];
            else if (bus_addr == OFFS_ENABLE) bus_rdata = enable_all[c];
         end
      end
   end

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));                                 // R6
   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (cause_all == '0 && enable_all == '0));        // R1
endmodule

// File: tb/doorbell_unit_tb_top.sv
module doorbell_unit_tb_top;
   localparam int NCPU = 3;
   localparam logic [31:0] IPI_M = 32'h0000_00FF;
   localparam logic [31:0] MSI_M = 32'hFFFF_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_global = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_cpu = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        msg_valid = 1'b0;
   logic [1:0]  msg_cpu = '0;
   logic [3:0]  msg_vec = '0;
   logic [NCPU-1:0] ipi_irq, msi_irq;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;
   logic [31:0] m_cause [4];
   logic [31:0] m_en    [4];

   always #2.5 clk = ~clk;

   doorbell_unit #(.NCPU(NCPU), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_global(bus_global), .bus_addr(bus_addr), .bus_cpu(bus_cpu),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
      .msg_cpu(msg_cpu), .msg_vec(msg_vec), .ipi_irq(ipi_irq), .msi_irq(msi_irq));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] set_bits(int k, logic g, logic w, logic [11:0] a,
                                            logic [31:0] d, logic mv, logic [1:0] mc, logic [3:0] vec);
      logic [31:0] s = '0;
      if (k < NCPU && g && w && a == 12'h004 && d[8+k]) s |= 32'd1 << d[4:0];
      if (k < NCPU && mv && int'(mc) == k) s |= 32'd1 << (16 + vec);
      return s;
   endfunction

   task automatic op(input logic g, input logic w, input logic [11:0] a, input logic [1:0] c,
                     input logic [31:0] d, input logic mv, input logic [1:0] mc, input logic [3:0] vec);
      logic [31:0] nc [4];
      logic [31:0] ne [4];
      @(negedge clk);
      bus_global = g; bus_wr = w; bus_addr = a; bus_cpu = c; bus_wdata = d;
      msg_valid = mv; msg_cpu = mc; msg_vec = vec;
      for (int k = 0; k < 4; k++) begin
         logic hit;
         hit = (k < NCPU) && w && !g && int'(c) == k;
         nc[k] = ((hit && a == 12'h008) ? (m_cause[k] & d) : m_cause[k]) | set_bits(k, g, w, a, d, mv, mc, vec);
         ne[k] = (hit && a == 12'h00C) ? d : m_en[k];
      end
      @(negedge clk);
      bus_wr = 1'b0; msg_valid = 1'b0; bus_global = 1'b0;
      for (int k = 0; k < 4; k++) begin
         m_cause[k] = nc[k];
         m_en[k]    = ne[k];
      end
   endtask

   task automatic rd(input logic [1:0] c, input logic [11:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_cpu = c; bus_addr = a; bus_global = 1'b0;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic check_all(input string req);
      logic [31:0] v;
      for (int k = 0; k < 4; k++) begin
         rd(2'(k), 12'h008, v);
         chk(v === m_cause[k], req, v, m_cause[k]);
         rd(2'(k), 12'h00C, v);
         chk(v === m_en[k], req, v, m_en[k]);
      end
      @(negedge clk);
      for (int k = 0; k < NCPU; k++) begin
         logic ei, em;
         ei = |(m_cause[k] & m_en[k] & IPI_M);
         em = |(m_cause[k] & m_en[k] & MSI_M);
         chk(ipi_irq[k] === ei, {req, " R8 ipi"}, 32'(ipi_irq[k]), 32'(ei));
         chk(msi_irq[k] === em, {req, " R8 msi"}, 32'(msi_irq[k]), 32'(em));
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd2718));
      for (int k = 0; k < 4; k++) begin m_cause[k] = '0; m_en[k] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");

      // R2 / R7: trigger doorbell 3 to CPUs 0 and 2 while disabled
      op(1, 1, 12'h004, 0, 32'h0000_0503, 0, 0, 0);
      check_all("R2 R7");

      // R3: bitmap bit of absent CPU 3, and accesses as CPU 3
      op(1, 1, 12'h004, 0, 32'h0000_0805, 0, 0, 0);
      op(0, 1, 12'h00C, 3, 32'hFFFF_FFFF, 0, 0, 0);
      op(0, 1, 12'h008, 3, 32'h0000_0000, 1, 3, 4'd2);
      check_all("R3");

      // R4: clear only bit 3 of CPU 0
      op(0, 1, 12'h008, 0, ~32'h0000_0008, 0, 0, 0);
      check_all("R4");

      // R6: enable writes and odd address reads
      op(0, 1, 12'h00C, 2, 32'h0000_00FF, 0, 0, 0);
      op(0, 1, 12'h00C, 1, 32'h0021_0410, 0, 0, 0);
      rd(1, 12'h010, v);
      chk(v === 32'h0, "R6 other addr", v, 32'h0);
      check_all("R6");

      // R10: registered summary lags one clock
      op(1, 1, 12'h004, 0, 32'h0000_0204, 0, 0, 0);
      chk(ipi_irq[1] === 1'b0, "R10 before", 32'(ipi_irq[1]), 32'h0);
      @(negedge clk);
      chk(ipi_irq[1] === 1'b1, "R10 after", 32'(ipi_irq[1]), 32'h1);

      // R8: doorbell 10 enabled and pending drives neither line
      op(0, 1, 12'h008, 1, 32'h0, 0, 0, 0);
      op(0, 1, 12'h00C, 1, 32'h0000_0400, 0, 0, 0);
      op(1, 1, 12'h004, 0, 32'h0000_020A, 0, 0, 0);
      check_all("R8");

      // R9: message to CPU 1 vector 5 -> doorbell 21
      op(0, 1, 12'h00C, 1, 32'h0020_0000, 1, 1, 4'd5);
      check_all("R9");

      // R5: message set collides with full clear on CPU 0
      op(0, 1, 12'h008, 0, 32'h0, 1, 0, 4'd4);
      rd(0, 12'h008, v);
      chk(v === 32'h0010_0000, "R5 set wins", v, 32'h0010_0000);

      // R9: bus trigger and message in the same cycle
      op(1, 1, 12'h004, 0, 32'h0000_0106, 1, 0, 4'd15);
      check_all("R9 same cycle");

      for (int i = 0; i < 400; i++) begin
         int sel;
         logic [31:0] d;
         sel = int'($urandom % 6);
         d = $urandom;
         case (sel)
            0: op(1, 1, 12'h004, 0, d, 0, 0, 0);
            1: op(0, 1, 12'h008, 2'($urandom % 4), d | 32'($urandom), 0, 0, 0);
            2: op(0, 1, 12'h00C, 2'($urandom % 4), d, 0, 0, 0);
            3: op(0, 0, 12'h000, 0, 0, 1, 2'($urandom % 4), 4'($urandom));
            4: op(1, 1, 12'h004, 0, d, 1, 2'($urandom % 4), 4'($urandom));
            default: op(0, 1, 12'h008, 2'($urandom % 4), d, 1, 2'($urandom % 4), 4'($urandom));
         endcase
         if (i % 4 == 3) check_all("R2 R4 R5 R9 random");
      end
      check_all("R2 R4 R9 final");

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule